// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control core of a single-item dispenser with a 15-cent price. Each clock cycle it may receive one coin pulse, either a 5-cent or a 10-cent coin, and it keeps a running amount in a four-state register covering 0, 5, 10 and "15 or more" cents. No change is given. A coin that pays more than the price is absorbed, and the controller stays in the paid state until it is reset.

Two release signals are produced side by side.

- The state-only release is driven straight from the state register. It therefore changes only at a clock edge, and it rises in the cycle after the completing coin.
- The input-dependent release is computed from the state and the current coin pulses. It rises in the same cycle as the coin that completes payment, before the register updates.

Coin pulses are single-cycle and already synchronous to the clock. A cycle in which both coin pulses are high is treated as a cycle with no coin.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no coin present, both release outputs are 0 and the amount is 0 cents. The state code for 0 cents is 2'b00.
- R2: A 5-cent pulse alone advances the amount by 5 cents. The state codes are 0 → 2'b00, 5 → 2'b01, 10 → 2'b10 and paid → 2'b11. Three 5-cent coins from 0 reach the paid state.
- R3: A 10-cent pulse alone advances the amount by 10 cents. From 0 it goes to 10 cents, and from 5 it goes to the paid state.
- R4: Overpayment is absorbed without refund. A 10-cent coin taken at 10 cents goes to the paid state, and the state does not advance beyond it.
- R5: `release_moore_o` is 1 exactly when the state is paid (2'b11). It rises in the cycle after the completing coin.
- R6: `release_mealy_o` is 1 when the state is paid or when the current coin completes payment. It is already 1 in the cycle of the completing coin.
- R7: Once paid, the controller stays paid for every coin pattern until `rst_n` goes low.
- R8: A cycle with both coin pulses high leaves the amount unchanged and does not raise `release_mealy_o` unless the state is already paid.
- R9: A cycle with no coin pulse leaves the amount unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coin_nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| coin_dime_i | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| release_moore_o | output | 1 | Release, from the state only |
| release_mealy_o | output | 1 | Release, from the state and the current coin |

## Verification
The bound checker tests on every cycle the following properties:
- the paid state is sticky;
- an idle cycle or a double-coin cycle holds the state;
- a single 5-cent coin from zero lands on 5 cents;
- the input-dependent release always leads or matches the state-only release by one cycle;
- reset releases into the zero state.

Properties that need a history of coins come from the bench's random and directed sequences, compared with a cents-based model. These are the exact amount reached after mixed coin sequences, overpayment through a 10-cent coin at 10 cents, and the same-cycle rise of the input-dependent release on the completing coin.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_ZERO = 2'b00,
    ST_FIVE = 2'b01,
    ST_TEN  = 2'b10,
    ST_PAID = 2'b11
  } vend_state_e;

  // Next-state implementation variants
  localparam int NS_EQUATIONS = 0;
  localparam int NS_TABLE     = 1;

endpackage

// File: rtl/vend_coin_decode.sv
// Turns the raw coin pulses into mutually exclusive qualified coins.
// A cycle with both pulses high is treated as a cycle with no coin.
module vend_coin_decode (
  input  logic nickel_raw_i,
  input  logic dime_raw_i,
  output logic nickel_o,
  output logic dime_o,
  output logic any_o
);

  always_comb begin
    nickel_o = nickel_raw_i & ~dime_raw_i;
    dime_o   = dime_raw_i & ~nickel_raw_i;
    any_o    = nickel_o | dime_o;
  end

endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
#(
  parameter int STYLE = NS_EQUATIONS
) (
  input  vend_state_e cur_i,
  input  logic        nickel_i,
  input  logic        dime_i,
  output vend_state_e nxt_o
);

  generate
    if (STYLE == NS_EQUATIONS) begin : g_eqn
      logic q1;
      logic q0;
      logic d1;
      logic d0;

      always_comb begin
        q1 = cur_i[1];
        q0 = cur_i[0];
        d1 = q1 | dime_i | (q0 & nickel_i);
        d0 = (nickel_i & ~q0) | (~nickel_i & q0) | (q1 & nickel_i) | (q1 & dime_i);
        nxt_o = vend_state_e'({d1, d0});
      end
    end else begin : g_table
      always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
          ST_ZERO: begin
            if (nickel_i)    nxt_o = ST_FIVE;
            else if (dime_i) nxt_o = ST_TEN;
          end
          ST_FIVE: begin
            if (nickel_i)    nxt_o = ST_TEN;
            else if (dime_i) nxt_o = ST_PAID;
          end
          ST_TEN: begin
            if (nickel_i | dime_i) nxt_o = ST_PAID;
          end
          default: nxt_o = ST_PAID;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  vend_state_e nxt_i,
  output vend_state_e state_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= ST_ZERO;
    end else if (en_i) begin
      state_o <= nxt_i;
    end
  end

endmodule

// File: rtl/vend_release.sv
module vend_release
  import vend_pkg::*;
(
  input  vend_state_e state_i,
  input  logic        nickel_i,
  input  logic        dime_i,
  output logic        moore_o,
  output logic        mealy_o
);

  logic q1;
  logic q0;

  always_comb begin
    q1      = state_i[1];
    q0      = state_i[0];
    moore_o = q1 & q0;
    mealy_o = (q1 & q0) | (dime_i & q0) | (dime_i & q1) | (nickel_i & q1);
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int NS_STYLE = NS_EQUATIONS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coin_nickel_i,
  input  logic coin_dime_i,
  output logic release_moore_o,
  output logic release_mealy_o
);

  logic        nickel_q;
  logic        dime_q;
  logic        coin_any;
  logic        state_en;
  vend_state_e state_q;
  vend_state_e state_nxt;

  vend_coin_decode u_decode (
    .nickel_raw_i (coin_nickel_i),
    .dime_raw_i   (coin_dime_i),
    .nickel_o     (nickel_q),
    .dime_o       (dime_q),
    .any_o        (coin_any)
  );

  vend_next_state #(.STYLE(NS_STYLE)) u_next (
    .cur_i    (state_q),
    .nickel_i (nickel_q),
    .dime_i   (dime_q),
    .nxt_o    (state_nxt)
  );

  // Clock enable: only a qualified coin in an unpaid state moves the register
  always_comb begin
    state_en = coin_any & (state_q != ST_PAID);
  end

  vend_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (state_en),
    .nxt_i   (state_nxt),
    .state_o (state_q)
  );

  vend_release u_release (
    .state_i  (state_q),
    .nickel_i (nickel_q),
    .dime_i   (dime_q),
    .moore_o  (release_moore_o),
    .mealy_o  (release_mealy_o)
  );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
  import vend_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        coin_nickel_i,
  input logic        coin_dime_i,
  input logic        release_moore_o,
  input logic        release_mealy_o,
  input vend_state_e state_q
);

  // R1: reset releases into the zero state
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (state_q == ST_ZERO && !release_moore_o));

  // R2: a lone 5-cent coin at zero lands on 5 cents
  p_nickel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (coin_nickel_i && !coin_dime_i && state_q == ST_ZERO) |=> (state_q == ST_FIVE));

  // R5: state-only release rises only after the input-dependent one was high
  p_moore_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_moore_o) |-> $past(release_mealy_o));

  // R6: input-dependent release high implies state-only release next cycle
  p_mealy_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_mealy_o |=> release_moore_o);

  // R6: state-only release implies input-dependent release
  p_moore_in_mealy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_moore_o |-> release_mealy_o);

  // R7: paid state is sticky
  p_paid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAID) |=> (state_q == ST_PAID));

  // R8: double-coin cycle holds the state
  p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (coin_nickel_i && coin_dime_i) |=> $stable(state_q));

  // R9: idle cycle holds the state
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!coin_nickel_i && !coin_dime_i) |=> $stable(state_q));

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .coin_nickel_i   (coin_nickel_i),
  .coin_dime_i     (coin_dime_i),
  .release_moore_o (release_moore_o),
  .release_mealy_o (release_mealy_o),
  .state_q         (state_q)
);

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/100ps
module vend_ctrl_tb;

  logic clk;
  logic rst_n;
  logic nick;
  logic dime;
  logic rel_moore;
  logic rel_mealy;

  int checks;
  int fails;
  int cents;   // bench model: 0, 5, 10 or 15 (paid)
  bit done;

  vend_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .coin_nickel_i   (nick),
    .coin_dime_i     (dime),
    .release_moore_o (rel_moore),
    .release_mealy_o (rel_mealy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int coin_value(input bit n, input bit d);
    if (n && !d) return 5;
    if (d && !n) return 10;
    return 0;
  endfunction

  function automatic int next_cents(input int c, input bit n, input bit d);
    int s;
    s = c + coin_value(n, d);
    return (s >= 15) ? 15 : s;
  endfunction

  function automatic bit exp_moore(input int c);
    return c >= 15;
  endfunction

  function automatic bit exp_mealy(input int c, input bit n, input bit d);
    return (c + coin_value(n, d)) >= 15;
  endfunction

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cents=%0d)", req, what, act, exp, cents);
    end
  endtask

  // Drive one coin cycle: check both releases mid-cycle, then advance the model
  task automatic step(input bit n, input bit d, input string req);
    @(negedge clk);
    nick = n;
    dime = d;
    #1;
    check(req, rel_moore, exp_moore(cents), "moore");
    check(req, rel_mealy, exp_mealy(cents, n, d), "mealy");
    @(posedge clk);
    cents = next_cents(cents, n, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    nick  = 1'b0;
    dime  = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", rel_moore, 1'b0, "moore in reset");
    check("R1", rel_mealy, 1'b0, "mealy in reset");
    @(negedge clk);
    rst_n = 1'b1;
    cents = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    nick   = 1'b0;
    dime   = 1'b0;
    rst_n  = 1'b0;
    cents  = 0;
    seed   = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    do_reset();
    step(1'b0, 1'b0, "R1");

    // R2: three 5-cent coins
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R6");  // completing coin: mealy high now
    step(1'b0, 1'b0, "R5");  // moore high one cycle later
    // R7: paid holds under every pattern
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    do_reset();

    // R3: 10 then 5 -> paid
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b0, "R5");
    do_reset();

    // R3: 5 then 10 -> paid
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R5");
    do_reset();

    // R4: 10 then 10 -> paid, no further advance
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R4");
    do_reset();

    // R8: double coins do nothing, then exact sequence still correct
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R8");

    // Random mix with occasional reset
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 15);
      if (r == 0) begin
        do_reset();
      end else begin
        bit rn;
        bit rd;
        rn = r[0];
        rd = r[1] & r[2];
        step(rn, rd, "R6");
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule